// File: doc/BRIEF.md
# Clock Gate Enable Bank with Set/Clear Access

This block holds the enable bits that gate two groups of clocks. The first group is the system clocks: a USB device clock, a USB host clock and four programmable clock outputs. The second group is the peripheral clocks, where each peripheral owns the bit at the position equal to its peripheral ID. Software never rewrites a whole enable word. It writes a mask to a set address to switch clocks on and a mask to a clear address to switch them off. Bits that are zero in the mask keep their state. Each bank's current enables are read back from its own status address.

The register bus is a single-cycle interface. An access is a cycle with `bus_valid` high. `bus_write` selects a write, and read data is returned in the same cycle. There is one access per cycle, so when one clock is set and cleared in two successive accesses, the later access wins. Every enable bit feeds a latch-based clock gate on its own source clock. The latch is transparent only while that source clock is low, so a change in the enable can never shorten or split a high phase of the gated clock.

Top module: `cg_gate_bank`

## Requirements
- R1: After synchronous active-low reset, every peripheral enable is 0 and the system enables equal the parameter `SYS_RESET` (default 6'h01).
- R2: A write to word address 0x0 ORs `bus_wdata[5:0]` into the system enables, and zero mask bits leave their bits unchanged. The bit map is: bit 0 USB device, bit 1 USB host, bits 2..5 programmable outputs 0..3. The new state appears on `sys_en` in the cycle after the write.
- R3: A write to address 0x1 clears every system enable whose mask bit is 1, and leaves all other bits unchanged.
- R4: Peripheral enables are set through address 0x4 and cleared through address 0x5 with the same rules as R2 and R3, and neither bank is changed by the other bank's addresses.
- R5: The enable for peripheral ID n is bit n of the peripheral mask, of `per_en` and of the peripheral status word.
- R6: A read of address 0x2 returns the system enables in bits [5:0] with the upper bits zero. A read of address 0x6 returns all peripheral enables.
- R7: Reads of the set addresses, the clear addresses and any unmapped address return zero.
- R8: Writes to the status addresses or to unmapped addresses change no enable bit.
- R9: Accesses take effect one per cycle in bus order: a set followed by a clear of the same bit leaves it off, and a clear followed by a set leaves it on.
- R10: Each gated clock is high only while its source clock is high and its latched enable is 1. The latched enable follows the register only while the source clock is low. A change made during a high phase therefore shows only from the next high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| sys_src_clk | input | 6 | Ungated system clock sources |
| per_src_clk | input | 32 | Ungated peripheral clock sources |
| sys_en | output | 6 | Registered system enables |
| per_en | output | 32 | Registered peripheral enables |
| sys_gclk | output | 6 | Gated system clocks |
| per_gclk | output | 32 | Gated peripheral clocks |

## Verification
The hardest case to reach is an enable that changes while its source clock is high. The gated output must then neither start nor stop in the middle of that high phase. The bench drives the source clocks itself. It holds a source high across a whole bus write, checks that the gated clock has not moved, and only then lets the source fall and rise again, once for a set and once for a clear. Ordering (R9) is covered by back-to-back accesses with no idle cycle between them. Each intermediate state is sampled between the two accesses.

// File: rtl/cg_bank_pkg.sv
// Package: shared address map, bit positions and decode types for the
// clock gate enable bank. Assumes word addressing on the register bus.
package cg_bank_pkg;

    // Word offsets; the set/clear/status split is what software relies on
    localparam int OFF_SYS_SET  = 0;
    localparam int OFF_SYS_CLR  = 1;
    localparam int OFF_SYS_STAT = 2;
    localparam int OFF_PER_SET  = 4;
    localparam int OFF_PER_CLR  = 5;
    localparam int OFF_PER_STAT = 6;

    // System bank bit positions
    localparam int SYS_BIT_USB_DEV = 0;
    localparam int SYS_BIT_USB_HST = 1;
    localparam int SYS_BIT_PROG0   = 2;
    localparam int SYS_PROG_COUNT  = 4;

    // Write strobes for one access
    typedef struct packed {
        logic sys_set;
        logic sys_clr;
        logic per_set;
        logic per_clr;
    } wr_strobe_t;

    // Read source selection
    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_SYS  = 2'd1,
        RD_PER  = 2'd2
    } rd_sel_t;

endpackage

// File: rtl/cg_bus_decode.sv
// Module: cg_bus_decode
// Turns one bus access into bank write strobes and a read source select.
// Assumes a single-cycle bus with at most one access per cycle. Writes to
// status or unmapped addresses produce no strobe. Reads of anything other
// than a status address select zero.
module cg_bus_decode
    import cg_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_strobe_t        wr_stb,
    output rd_sel_t           rd_sel
);

    localparam logic [ADDR_W-1:0] A_SYS_SET  = ADDR_W'(OFF_SYS_SET);
    localparam logic [ADDR_W-1:0] A_SYS_CLR  = ADDR_W'(OFF_SYS_CLR);
    localparam logic [ADDR_W-1:0] A_SYS_STAT = ADDR_W'(OFF_SYS_STAT);
    localparam logic [ADDR_W-1:0] A_PER_SET  = ADDR_W'(OFF_PER_SET);
    localparam logic [ADDR_W-1:0] A_PER_CLR  = ADDR_W'(OFF_PER_CLR);
    localparam logic [ADDR_W-1:0] A_PER_STAT = ADDR_W'(OFF_PER_STAT);

    logic do_wr;
    logic do_rd;

    assign do_wr = bus_valid && bus_write;
    assign do_rd = bus_valid && !bus_write;

    // Write strobe decode: only the set and clear addresses act
    always_comb begin
        wr_stb         = '0;
        wr_stb.sys_set = do_wr && (bus_addr == A_SYS_SET);
        wr_stb.sys_clr = do_wr && (bus_addr == A_SYS_CLR);
        wr_stb.per_set = do_wr && (bus_addr == A_PER_SET);
        wr_stb.per_clr = do_wr && (bus_addr == A_PER_CLR);
    end

    // Read source decode: only the status addresses return state
    always_comb begin
        rd_sel = RD_ZERO;
        if (do_rd) begin
            if (bus_addr == A_SYS_STAT)
                rd_sel = RD_SYS;
            else if (bus_addr == A_PER_STAT)
                rd_sel = RD_PER;
        end
    end

endmodule

// File: rtl/cg_enable_bank.sv
// Module: cg_enable_bank
// One bank of enable flops changed by set and clear masks. Assumes the
// decoder never raises both strobes in one cycle (one access per cycle).
// Reset value is a parameter.
module cg_enable_bank #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] state
);

    // State update: OR in on set, mask off on clear, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RST_VAL;
        else if (set_stb)
            state <= state | mask;
        else if (clr_stb)
            state <= state & ~mask;
    end

endmodule

// File: rtl/cg_clock_gate.sv
// Module: cg_clock_gate
// Latch-based clock gate for one clock. The enable is captured while the
// source clock is low and held while it is high, so the output never
// starts or stops inside a high phase. Assumes the enable settles
// while the source clock is low.
module cg_clock_gate (
    input  logic src_clk,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // Enable latch: transparent in the low phase of the source clock
    always_latch begin
        if (!src_clk)
            en_lat = en;
    end

    assign gclk = src_clk & en_lat;

endmodule

// File: rtl/cg_gate_bank.sv
// Module: cg_gate_bank
// Top of the clock gate enable bank. It holds a system bank (USB device,
// USB host, programmable outputs) and a peripheral bank indexed by ID.
// Each bank is changed through write-one-to-set and write-one-to-clear
// addresses and read through a status address. Every bit drives its own
// latch-based gate. Assumes SYS_W and PER_W do not exceed DATA_W.
module cg_gate_bank
    import cg_bank_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 32,
    parameter int                SYS_W     = SYS_BIT_PROG0 + SYS_PROG_COUNT,
    parameter int                PER_W     = 32,
    parameter logic [SYS_W-1:0]  SYS_RESET = SYS_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SYS_W-1:0]  sys_src_clk,
    input  logic [PER_W-1:0]  per_src_clk,
    output logic [SYS_W-1:0]  sys_en,
    output logic [PER_W-1:0]  per_en,
    output logic [SYS_W-1:0]  sys_gclk,
    output logic [PER_W-1:0]  per_gclk
);

    wr_strobe_t wr_stb;
    rd_sel_t    rd_sel;

    cg_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_stb    (wr_stb),
        .rd_sel    (rd_sel)
    );

    cg_enable_bank #(.W(SYS_W), .RST_VAL(SYS_RESET)) u_sys_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_stb.sys_set),
        .clr_stb (wr_stb.sys_clr),
        .mask    (bus_wdata[SYS_W-1:0]),
        .state   (sys_en)
    );

    cg_enable_bank #(.W(PER_W), .RST_VAL('0)) u_per_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_stb.per_set),
        .clr_stb (wr_stb.per_clr),
        .mask    (bus_wdata[PER_W-1:0]),
        .state   (per_en)
    );

    // Read data mux: status words zero-extended, everything else zero
    always_comb begin
        case (rd_sel)
            RD_SYS:  bus_rdata = DATA_W'(sys_en);
            RD_PER:  bus_rdata = DATA_W'(per_en);
            default: bus_rdata = '0;
        endcase
    end

    // One gate cell per system clock
    for (genvar gi = 0; gi < SYS_W; gi++) begin : g_sys_gate
        cg_clock_gate u_gate (
            .src_clk (sys_src_clk[gi]),
            .en      (sys_en[gi]),
            .gclk    (sys_gclk[gi])
        );
    end

    // One gate cell per peripheral clock, indexed by peripheral ID
    for (genvar gi = 0; gi < PER_W; gi++) begin : g_per_gate
        cg_clock_gate u_gate (
            .src_clk (per_src_clk[gi]),
            .en      (per_en[gi]),
            .gclk    (per_gclk[gi])
        );
    end

endmodule

// File: rtl/cg_gate_bank_chk.sv
// Module: cg_gate_bank_chk
// Property checker for cg_gate_bank, attached by bind. It observes only
// the ports of the top module.
module cg_gate_bank_chk
    import cg_bank_pkg::*;
#(
    parameter int               ADDR_W    = 4,
    parameter int               DATA_W    = 32,
    parameter int               SYS_W     = 6,
    parameter int               PER_W     = 32,
    parameter logic [SYS_W-1:0] SYS_RESET = SYS_W'(1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SYS_W-1:0]  sys_src_clk,
    input logic [PER_W-1:0]  per_src_clk,
    input logic [SYS_W-1:0]  sys_en,
    input logic [PER_W-1:0]  per_en,
    input logic [SYS_W-1:0]  sys_gclk,
    input logic [PER_W-1:0]  per_gclk
);

    logic wr_sys_set, wr_sys_clr, wr_per_set, wr_per_clr, rd_zero;

    assign wr_sys_set = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_SYS_SET));
    assign wr_sys_clr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_SYS_CLR));
    assign wr_per_set = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_PER_SET));
    assign wr_per_clr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_PER_CLR));
    assign rd_zero    = bus_valid && !bus_write &&
                        (bus_addr != ADDR_W'(OFF_SYS_STAT)) &&
                        (bus_addr != ADDR_W'(OFF_PER_STAT));

    // R1: enables at their reset values on the first cycle out of reset
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sys_en == SYS_RESET) && (per_en == '0));

    // R2: a system set ORs the mask into the enables
    assert_sys_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sys_set |=> sys_en == ($past(sys_en) | $past(bus_wdata[SYS_W-1:0])));

    // R3: a system clear masks enables off
    assert_sys_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sys_clr |=> sys_en == ($past(sys_en) & ~$past(bus_wdata[SYS_W-1:0])));

    // R4: peripheral set and clear
    assert_per_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_per_set |=> per_en == ($past(per_en) | $past(bus_wdata[PER_W-1:0])));
    assert_per_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_per_clr |=> per_en == ($past(per_en) & ~$past(bus_wdata[PER_W-1:0])));

    // R8: no other access moves either bank
    assert_sys_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sys_set || wr_sys_clr) |=> $stable(sys_en));
    assert_per_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_per_set || wr_per_clr) |=> $stable(per_en));

    // R6: status reads mirror the enables
    assert_stat_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'(OFF_SYS_STAT))
            |-> bus_rdata == DATA_W'(sys_en));

    // R7: all other reads return zero
    assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |-> bus_rdata == '0);

    // R10: a gated clock is never high while its source is low
    assert_gate_sys_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_gclk & ~sys_src_clk) == '0);
    assert_gate_per_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (per_gclk & ~per_src_clk) == '0);

endmodule

bind cg_gate_bank cg_gate_bank_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SYS_W     (SYS_W),
    .PER_W     (PER_W),
    .SYS_RESET (SYS_RESET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_src_clk (sys_src_clk),
    .per_src_clk (per_src_clk),
    .sys_en      (sys_en),
    .per_en      (per_en),
    .sys_gclk    (sys_gclk),
    .per_gclk    (per_gclk)
);

// File: tb/cg_gate_bank_bench.sv
// Directed bench for cg_gate_bank: one task per scenario.
module cg_gate_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  sys_src_clk = '0;
    logic [31:0] per_src_clk = '0;
    logic [5:0]  sys_en;
    logic [31:0] per_en;
    logic [5:0]  sys_gclk;
    logic [31:0] per_gclk;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cg_gate_bank u_cg_gate_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sys_src_clk (sys_src_clk),
        .per_src_clk (per_src_clk),
        .sys_en      (sys_en),
        .per_en      (per_en),
        .sys_gclk    (sys_gclk),
        .per_gclk    (per_gclk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sys reset", 32'(sys_en), 32'h01);
        chk("R1 per reset", per_en, 32'h0);
    endtask

    task automatic t_sys_set();
        bus_wr(4'h0, 32'h0000_0014);          // prog out 0 and 2
        chk("R2 set keeps USB dev", 32'(sys_en), 32'h15);
        bus_wr(4'h0, 32'h0000_0002);          // USB host
        chk("R2 set USB host", 32'(sys_en), 32'h17);
        bus_wr(4'h0, 32'h0000_0000);
        chk("R2 zero mask", 32'(sys_en), 32'h17);
    endtask

    task automatic t_sys_clr();
        bus_wr(4'h1, 32'h0000_0005);
        chk("R3 clear mask", 32'(sys_en), 32'h12);
        bus_wr(4'h1, 32'h0000_003F);
        chk("R3 clear all", 32'(sys_en), 32'h00);
    endtask

    task automatic t_per_bank();
        bus_wr(4'h0, 32'h0000_0008);          // sys prog out 1
        bus_wr(4'h4, 32'hA500_00F0);
        chk("R4 per set", per_en, 32'hA500_00F0);
        chk("R4 sys untouched by per", 32'(sys_en), 32'h08);
        bus_wr(4'h5, 32'h8000_0030);
        chk("R4 per clear", per_en, 32'h2500_00C0);
        bus_wr(4'h1, 32'hFFFF_FFFF);
        chk("R4 per untouched by sys", per_en, 32'h2500_00C0);
        bus_wr(4'h5, 32'hFFFF_FFFF);
    endtask

    task automatic t_per_id();
        logic [31:0] r;
        for (int id = 0; id < 32; id += 9) begin
            bus_wr(4'h4, 32'(1) << id);
            chk("R5 per id bit", per_en, 32'(1) << id);
            bus_rd(4'h6, r);
            chk("R5 per id status", r, 32'(1) << id);
            bus_wr(4'h5, 32'(1) << id);
        end
    endtask

    task automatic t_status_read();
        logic [31:0] r;
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h2, r);
        chk("R6 sys status upper zero", r, 32'h3F);
        bus_wr(4'h4, 32'h1234_5678);
        bus_rd(4'h6, r);
        chk("R6 per status", r, 32'h1234_5678);
    endtask

    task automatic t_zero_reads();
        logic [31:0] r;
        bus_rd(4'h0, r); chk("R7 read sys set", r, 0);
        bus_rd(4'h1, r); chk("R7 read sys clr", r, 0);
        bus_rd(4'h4, r); chk("R7 read per set", r, 0);
        bus_rd(4'h5, r); chk("R7 read per clr", r, 0);
        bus_rd(4'h9, r); chk("R7 read unmapped", r, 0);
    endtask

    task automatic t_ro_writes();
        bus_wr(4'h2, 32'h0);
        bus_wr(4'h6, 32'h0);
        bus_wr(4'h3, 32'h0);
        bus_wr(4'hF, 32'hFFFF_FFFF);
        chk("R8 sys after ro writes", 32'(sys_en), 32'h3F);
        chk("R8 per after ro writes", per_en, 32'h1234_5678);
        bus_wr(4'h1, 32'h3F);
        bus_wr(4'h5, 32'hFFFF_FFFF);
    endtask

    task automatic t_ordering();
        // set then clear bit 3, no idle cycle between
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h8;
        @(negedge clk);
        chk("R9 mid set", 32'(sys_en), 32'h08);
        bus_addr = 4'h1;
        @(negedge clk);
        chk("R9 set then clear", 32'(sys_en), 32'h00);
        // clear then set peripheral bit 20
        bus_addr = 4'h5; bus_wdata = 32'h0010_0000;
        @(negedge clk);
        chk("R9 mid clear", per_en, 32'h0);
        bus_addr = 4'h4;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk("R9 clear then set", per_en, 32'h0010_0000);
        bus_wr(4'h5, 32'hFFFF_FFFF);
    endtask

    task automatic t_gate();
        sys_src_clk[0] = 1'b0; per_src_clk[7] = 1'b0;
        @(negedge clk);
        sys_src_clk[0] = 1'b1; per_src_clk[7] = 1'b1;
        #1;
        bus_wr(4'h0, 32'h1);
        bus_wr(4'h4, 32'h80);
        chk("R10 sys en set", 32'(sys_en[0]), 1);
        chk("R10 no start mid-high sys", 32'(sys_gclk[0]), 0);
        chk("R10 no start mid-high per", 32'(per_gclk[7]), 0);
        sys_src_clk[0] = 1'b0; per_src_clk[7] = 1'b0; #1;
        chk("R10 low phase", 32'(sys_gclk[0]), 0);
        sys_src_clk[0] = 1'b1; per_src_clk[7] = 1'b1; #1;
        chk("R10 sys runs", 32'(sys_gclk[0]), 1);
        chk("R10 per runs", 32'(per_gclk[7]), 1);
        bus_wr(4'h1, 32'h1);
        bus_wr(4'h5, 32'h80);
        chk("R10 no stop mid-high sys", 32'(sys_gclk[0]), 1);
        chk("R10 no stop mid-high per", 32'(per_gclk[7]), 1);
        sys_src_clk[0] = 1'b0; per_src_clk[7] = 1'b0; #1;
        sys_src_clk[0] = 1'b1; per_src_clk[7] = 1'b1; #1;
        chk("R10 sys stopped", 32'(sys_gclk[0]), 0);
        chk("R10 per stopped", 32'(per_gclk[7]), 0);
        sys_src_clk[0] = 1'b0; per_src_clk[7] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a miscompare
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Scenario sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sys_set();
        t_sys_clr();
        t_per_bank();
        t_per_id();
        t_status_read();
        t_zero_reads();
        t_ro_writes();
        t_ordering();
        t_gate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule